// File: doc/BRIEF.md
# Sleep Power-Down and Sleep-Exception Controller

This controller sits beside a simple CPU sequencer and decides what a retired SLEEP instruction does. A mode input picks the outcome. With the mode input low, the core drops into a power-down state. It stays there until a new rising edge appears on one of the wake-up interrupt request lines. The controller then leaves power-down and raises a one-cycle exception request for that interrupt. With the mode input high, no power-down happens. The SLEEP instead raises a dedicated sleep exception in the very next cycle.

The controller tracks whether an exception handler is in progress. A handler ends when the sequencer pulses the return strobe. SLEEP is accepted whenever the core is executing, and this includes code inside a handler. So a handler that sets the mode input before its final SLEEP gets the sleep exception, not power-down. Only edges on the wake-up lines that arrive after power-down entry can end power-down. A line that rose earlier, or that is simply held high, never wakes the core. A configuration flag reports any accepted SLEEP that found both the mode input and the standby-select input high.

All pins are plain control and status signals. There is no valid/ready stream, so no back-pressure applies. The exception request is a single-cycle strobe that the sequencer must take in the cycle it appears.

Top module: `slp_pd_ctrl`

## Requirements
- R1: With `slp_exc_en_i` low, a `sleep_retire_i` pulse accepted outside power-down makes `pd_o` high from the next cycle. `pd_o` then stays high until a wake-up edge is seen.
- R2: In power-down, a rising edge on any `wake_req_i` bit ends power-down at the next clock edge. In that cycle `pd_o` falls, `exc_req_o` is high, `exc_vec_o` is 0 and `exc_src_o` holds the lowest-numbered bit that rose.
- R3: With `slp_exc_en_i` high, an accepted SLEEP gives `exc_req_o` high with `exc_vec_o` = 1 in the next cycle, and `pd_o` stays low.
- R4: SLEEP is accepted in every state except power-down, including while a handler is active. When `sleep_retire_i` and `exc_ret_i` arrive in the same cycle, the SLEEP takes effect and the return is dropped.
- R5: A wake-up edge that arrives before or in the same cycle as power-down entry does not end that power-down. A wake-up line held high does not end it either.
- R6: An accepted SLEEP with both `slp_exc_en_i` and `stby_sel_i` high sets `cfg_err_o` and takes the sleep-exception path. Any later accepted SLEEP without both inputs high clears `cfg_err_o`.
- R7: While in power-down, `sleep_retire_i` is ignored. `pd_o` stays high and no exception request is made.
- R8: `exc_req_o` is high for exactly one cycle per accepted event. `in_handler_o` is high from that cycle until an `exc_ret_i` pulse is accepted. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_retire_i | input | 1 | One-cycle pulse: a SLEEP instruction retired |
| slp_exc_en_i | input | 1 | Mode: 1 = raise the sleep exception, 0 = power down |
| stby_sel_i | input | 1 | Standby-select setting, checked for a conflict |
| wake_req_i | input | NUM_WAKE | Wake-up interrupt request levels |
| exc_ret_i | input | 1 | One-cycle pulse: exception handler returned |
| pd_o | output | 1 | Power-down / clock-stop indication |
| exc_req_o | output | 1 | One-cycle exception request strobe |
| exc_vec_o | output | 1 | Vector select: 0 = wake interrupt, 1 = sleep exception |
| exc_src_o | output | IDX_W | Index of the wake-up line that ended power-down |
| in_handler_o | output | 1 | An exception handler is in progress |
| cfg_err_o | output | 1 | Last accepted SLEEP found both mode and standby high |

## Verification
Two pairs of events can land in the same cycle. The first is a wake-up edge arriving together with the SLEEP that enters power-down. The second is a SLEEP retiring in the same cycle as a handler return. The bench drives both on purpose, and a random phase hits them again many times. Its behavioural model decides the outcome by the rules above: the early edge must not wake, and the SLEEP must win over the return. The model is compared with the design at every falling edge.

// File: rtl/slp_pd_pkg.sv
package slp_pd_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_PWRDN    = 2'd1,
    ST_WAKE_EXC = 2'd2,
    ST_SLP_EXC  = 2'd3
  } slp_state_e;

  localparam logic VEC_IRQ = 1'b0;
  localparam logic VEC_SLP = 1'b1;
endpackage

// File: rtl/slp_wake_edge.sv
module slp_wake_edge #(
  parameter int NUM_WAKE = 4,
  parameter int IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_WAKE-1:0] req_i,
  output logic                hit_o,
  output logic [IDX_W-1:0]    idx_o
);
  logic [NUM_WAKE-1:0] prev_q;
  logic [NUM_WAKE-1:0] rise;

  // one history flop per request line
  for (genvar g = 0; g < NUM_WAKE; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= req_i[g];
    end
    assign rise[g] = req_i[g] & ~prev_q[g];
  end

  assign hit_o = |rise;

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_WAKE - 1; i >= 0; i--) begin
      if (rise[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/slp_pd_fsm.sv
module slp_pd_fsm
  import slp_pd_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_i,
  input  logic             exc_en_i,
  input  logic             stby_i,
  input  logic             ret_i,
  input  logic             wake_hit_i,
  input  logic [IDX_W-1:0] wake_idx_i,
  output logic             pd_o,
  output logic             req_o,
  output logic             vec_o,
  output logic [IDX_W-1:0] src_o,
  output logic             busy_o,
  output logic             cfg_err_o
);
  slp_state_e state_q, state_d;
  logic req_d, vec_d, cfg_d;
  logic [IDX_W-1:0] src_d;
  logic accept;

  assign accept = sleep_i && (state_q != ST_PWRDN);

  always_comb begin
    state_d = state_q;
    req_d   = 1'b0;
    vec_d   = vec_o;
    src_d   = src_o;
    cfg_d   = cfg_err_o;
    if (accept) begin
      cfg_d = exc_en_i & stby_i;
      if (exc_en_i) begin
        state_d = ST_SLP_EXC;
        req_d   = 1'b1;
        vec_d   = VEC_SLP;
      end else begin
        state_d = ST_PWRDN;
      end
    end else if (state_q == ST_PWRDN) begin
      if (wake_hit_i) begin
        state_d = ST_WAKE_EXC;
        req_d   = 1'b1;
        vec_d   = VEC_IRQ;
        src_d   = wake_idx_i;
      end
    end else if (ret_i && (state_q != ST_RUN)) begin
      state_d = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      req_o     <= 1'b0;
      vec_o     <= 1'b0;
      src_o     <= '0;
      cfg_err_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      req_o     <= req_d;
      vec_o     <= vec_d;
      src_o     <= src_d;
      cfg_err_o <= cfg_d;
    end
  end

  assign pd_o   = (state_q == ST_PWRDN);
  assign busy_o = (state_q == ST_WAKE_EXC) || (state_q == ST_SLP_EXC);

  p_pd_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !exc_en_i) |=> (pd_o && !req_o));

  p_wake_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_o && wake_hit_i) |=> (!pd_o && req_o && !vec_o && busy_o));

  p_slp_exc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && exc_en_i) |=> (req_o && vec_o && !pd_o));

  p_cfg_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && exc_en_i && stby_i) |=> (cfg_err_o && vec_o));

  p_pd_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_o && sleep_i && !wake_hit_i) |=> (pd_o && !req_o));

  p_ret_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ret_i && !sleep_i) |=> (!busy_o && !pd_o && !req_o));
endmodule

// File: rtl/slp_pd_ctrl.sv
module slp_pd_ctrl #(
  parameter int NUM_WAKE = 4,
  parameter int IDX_W    = (NUM_WAKE > 1) ? $clog2(NUM_WAKE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_retire_i,
  input  logic                slp_exc_en_i,
  input  logic                stby_sel_i,
  input  logic [NUM_WAKE-1:0] wake_req_i,
  input  logic                exc_ret_i,
  output logic                pd_o,
  output logic                exc_req_o,
  output logic                exc_vec_o,
  output logic [IDX_W-1:0]    exc_src_o,
  output logic                in_handler_o,
  output logic                cfg_err_o
);
  logic             wake_hit;
  logic [IDX_W-1:0] wake_idx;

  slp_wake_edge #(.NUM_WAKE(NUM_WAKE), .IDX_W(IDX_W)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (wake_req_i),
    .hit_o (wake_hit),
    .idx_o (wake_idx)
  );

  slp_pd_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_i    (sleep_retire_i),
    .exc_en_i   (slp_exc_en_i),
    .stby_i     (stby_sel_i),
    .ret_i      (exc_ret_i),
    .wake_hit_i (wake_hit),
    .wake_idx_i (wake_idx),
    .pd_o       (pd_o),
    .req_o      (exc_req_o),
    .vec_o      (exc_vec_o),
    .src_o      (exc_src_o),
    .busy_o     (in_handler_o),
    .cfg_err_o  (cfg_err_o)
  );

  // an edge already present at entry must not reach the state machine as a wake
  p_early_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pd_o) && (wake_req_i == $past(wake_req_i))) |-> !wake_hit);
endmodule

// File: tb/test_slp_pd_ctrl.sv
module test_slp_pd_ctrl;
  localparam int NW = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sl = 1'b0, en = 1'b0, sb = 1'b0, ret = 1'b0;
  logic [NW-1:0] wk = '0;
  logic pd, req, vec, hand, cfg;
  logic [IW-1:0] src;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  slp_pd_ctrl #(.NUM_WAKE(NW)) i_slp_pd_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_retire_i(sl), .slp_exc_en_i(en),
    .stby_sel_i(sb), .wake_req_i(wk), .exc_ret_i(ret), .pd_o(pd),
    .exc_req_o(req), .exc_vec_o(vec), .exc_src_o(src),
    .in_handler_o(hand), .cfg_err_o(cfg)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 run, 1 powered down, 2 wake handler, 3 sleep handler
  int m_st = 0;
  logic m_pd = 0, m_req = 0, m_vec = 0, m_cfg = 0;
  int m_src = 0;
  logic [NW-1:0] m_prev = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_req = 0; m_vec = 0; m_cfg = 0; m_src = 0; m_prev = '0;
    end else begin
      logic [NW-1:0] rise;
      rise = wk & ~m_prev;
      m_prev = wk;
      m_req = 0;
      if (m_st != 1) begin
        if (sl) begin
          m_cfg = en & sb;
          if (en) begin m_st = 3; m_req = 1; m_vec = 1; end
          else m_st = 1;
        end else if (ret && m_st >= 2) m_st = 0;
      end else if (rise != 0) begin
        m_st = 2; m_req = 1; m_vec = 0;
        for (int i = NW - 1; i >= 0; i--) if (rise[i]) m_src = i;
      end
    end
    m_pd = (m_st == 1);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(pd == m_pd, "R1 pd_o", pd, m_pd);
      check(req == m_req, "R8 exc_req_o", req, m_req);
      check(hand == (m_st >= 2), "R8 in_handler_o", hand, m_st >= 2);
      check(cfg == m_cfg, "R6 cfg_err_o", cfg, m_cfg);
      if (m_req) check(vec == m_vec, "R3 exc_vec_o", vec, m_vec);
      if (m_req && !m_vec) check(src == IW'(m_src), "R2 exc_src_o", src, m_src);
    end
  end

  task automatic step(input logic s, input logic e, input logic b,
                      input logic [NW-1:0] w, input logic r);
    @(negedge clk);
    sl = s; en = e; sb = b; wk = w; ret = r;
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0);
    check(!pd && !req && !hand && !cfg, "R8 reset state", {pd, req, hand, cfg}, 0);

    // R1 power-down entry and hold
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check(pd == 1, "R1 entry", pd, 1);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check(pd == 1, "R1 hold", pd, 1);
    // R7 SLEEP ignored while powered down
    step(1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check(pd == 1 && !req, "R7 sleep ignored", pd, 1);
    // R2 wake on line 2
    step(0, 0, 0, 4'b0100, 0);
    step(0, 0, 0, 4'b0100, 0);
    check(!pd && req && vec == 0 && src == 2, "R2 wake request", src, 2);
    step(0, 0, 0, 0, 0);
    check(!req && hand, "R8 single pulse", req, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    check(!hand && !pd, "R8 return", hand, 0);

    // R5 edge in the same cycle as entry, then level held
    step(1, 0, 0, 4'b0001, 0);
    step(0, 0, 0, 4'b0001, 0);
    check(pd && !req, "R5 same-cycle edge", pd, 1);
    step(0, 0, 0, 4'b0001, 0);
    step(0, 0, 0, 4'b0001, 0);
    check(pd && !req, "R5 held level", pd, 1);
    step(0, 0, 0, 4'b0000, 0);
    step(0, 0, 0, 4'b1010, 0);
    step(0, 0, 0, 4'b0000, 0);
    check(req && !vec && src == 1, "R2 lowest index", src, 1);
    step(0, 0, 0, 0, 1);
    // R5 edge before SLEEP
    step(0, 0, 0, 4'b1000, 0);
    step(1, 0, 0, 4'b1000, 0);
    step(0, 0, 0, 4'b1000, 0);
    step(0, 0, 0, 4'b1000, 0);
    check(pd && !req, "R5 earlier edge", pd, 1);
    step(0, 0, 0, 4'b0000, 0);
    step(0, 0, 0, 4'b0001, 0);
    step(0, 0, 0, 4'b0000, 0);
    check(req && !pd, "R2 fresh edge", req, 1);

    // R4 enable set inside the wake handler: next SLEEP gives the sleep exception
    step(1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check(req && vec && !pd && hand, "R4 sleep in handler", vec, 1);
    check(!cfg, "R3 no cfg error", cfg, 0);
    step(0, 0, 0, 0, 1);
    // R3 from run
    step(1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check(req && vec && !pd, "R3 sleep exception", {req, vec, pd}, 3'b110);
    // R6 conflict
    step(1, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    check(cfg && req && vec && !pd, "R6 conflict flagged", cfg, 1);
    // R4 SLEEP with return in same cycle: SLEEP wins
    step(1, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    check(pd && !cfg, "R4 sleep beats return", pd, 1);
    check(!cfg, "R6 cleared", cfg, 0);
    step(0, 0, 0, 4'b0010, 0);
    step(0, 0, 0, 0, 1);

    // random phase, judged by the model every cycle
    for (int k = 0; k < 4000; k++) begin
      logic [NW-1:0] w;
      w = wk;
      if ($urandom_range(0, 3) == 0) w = NW'($urandom);
      step(($urandom_range(0, 5) == 0), $urandom_range(0, 1) == 1,
           ($urandom_range(0, 3) == 0), w, ($urandom_range(0, 4) == 0));
    end
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule